// File: doc/BRIEF.md
# Audio FIFO Sample Feeder

This block holds two independent byte queues of signed 8-bit audio samples that feed a digital mixer. Software or a DMA engine fills each queue one 32-bit word at a time. Each queue is bound to one of four hardware timers through its own timer-select input. Each time that timer overflows, the queue moves its oldest sample into an output latch, which the mixer reads.

When a queue is running low, the block asks for more data. After every overflow that a queue serves, the block checks how much data is left. If less than half the queue is filled, it sends a single-cycle refill request to the DMA channel that serves that queue. Queue 0 is served by DMA channel 1 and queue 1 by DMA channel 2. A clear input per channel discards queued data at once.

The write port of each channel uses valid/ready. `wr_ready` is held high at all times, so the port never applies back-pressure. A word is accepted in every cycle in which `wr_valid` is high. Any of its bytes that do not fit in the free space are dropped. Overflow pulses, timer selects, clear strobes, latches and requests are plain signals.

Top module: `audio_feed`

## Requirements
- R1: Each channel responds only to an overflow pulse of the timer whose index equals its 2-bit `tmr_sel` field (`tmr_sel[2n+1:2n]` for channel n). Pulses from other timers leave its latch, its queue and its request unchanged.
- R2: On a matching overflow with a non-empty queue, the oldest byte is loaded into the channel's `sample_q` byte (bits `[8n+7:8n]`), visible one cycle later. Between matching overflows the latch holds its value.
- R3: On a matching overflow with an empty queue, the channel's latch becomes 8'h00.
- R4: In the cycle after a matching overflow, the channel's refill request is high for exactly that cycle, if the occupancy at the end of the overflow cycle is below 16 bytes. That occupancy includes the pop and any write in the same cycle. In all other cases the request stays low.
- R5: The request of channel 0 appears on `dma_req[1]` and that of channel 1 on `dma_req[2]`. `dma_req[0]` and `dma_req[3]` stay low.
- R6: An accepted word is queued as four bytes, `wr_data[7:0]` of the channel's 32-bit slice first and bits `[31:24]` last.
- R7: Each queue holds 32 bytes and `wr_ready` is always high. When a word arrives with fewer than four bytes free (counted from the occupancy at the start of the cycle), only the low-order bytes that fit are kept and the rest are dropped.
- R8: A `chan_clr` pulse empties that channel's queue, zeroes its latch and cancels its request within one cycle. It overrides a write or overflow in the same cycle.
- R9: A write and a matching overflow in the same cycle are both served: the pop sees the occupancy from before the write, and no byte is lost or duplicated.
- R10: After reset, both latches are zero, all requests are low and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 2 | Write valid, one bit per channel |
| wr_data | input | 64 | Write words, 32 bits per channel (channel n at [32n+31:32n]) |
| wr_ready | output | 2 | Write ready, always high |
| tmr_ovf | input | 4 | Overflow pulses, bit t from timer t |
| tmr_sel | input | 4 | Timer index per channel, 2 bits each |
| chan_clr | input | 2 | Synchronous clear per channel |
| sample_q | output | 16 | Signed sample latches, 8 bits per channel |
| dma_req | output | 4 | Refill requests indexed by DMA channel |

## Verification
Every result of this block is due at the first rising edge after its stimulus. This covers a latch update from an overflow, the refill pulse, the effect of a clear, and a write becoming poppable. The bench applies each stimulus at a falling edge and samples at the next falling edge, half a period after the edge that produced the result. It clears the stimulus at that point, so a request that lasted longer than one cycle would show up in the following sample. Queue contents and occupancy are observed only through later pops, including the pop that returns zero at the exact point where the queue should be empty.

// File: rtl/afeed_pkg.sv
`timescale 1ns/1ps
package afeed_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
endpackage

// File: rtl/afeed_fifo.sv
`timescale 1ns/1ps
module afeed_fifo #(
  parameter int DEPTH = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                push,
  input  logic [afeed_pkg::WORD_W-1:0]        push_data,
  input  logic                                pop,
  output logic [afeed_pkg::BYTE_W-1:0]        pop_data,
  output logic                                empty,
  output logic [$clog2(DEPTH+1)-1:0]          fill_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WB = afeed_pkg::WORD_BYTES;
  localparam int BW = afeed_pkg::BYTE_W;

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt, space, n_acc;
  logic          pop_ok;

  always_comb begin
    space = CW'(DEPTH) - cnt;
    n_acc = '0;
    if (push && !clr) n_acc = (space >= CW'(WB)) ? CW'(WB) : space;
    pop_ok   = pop && !clr && (cnt != '0);
    fill_nxt = clr ? '0 : (cnt - CW'(pop_ok) + n_acc);
  end

  assign empty    = (cnt == '0);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      cnt  <= fill_nxt;
      wptr <= wptr + AW'(n_acc);
      if (pop_ok) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WB; k++) begin
      if (CW'(k) < n_acc) mem[wptr + AW'(k)] <= push_data[k*BW +: BW];
    end
  end

  // R7
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && cnt == CW'(DEPTH)) |=> $stable(cnt));

  // R8
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/afeed_chan.sv
`timescale 1ns/1ps
module afeed_chan #(
  parameter int DEPTH    = 32,
  parameter int NTMR     = 4,
  parameter int LOW_MARK = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          wr_valid,
  input  logic [afeed_pkg::WORD_W-1:0]  wr_data,
  output logic                          wr_ready,
  input  logic [NTMR-1:0]               ovf,
  input  logic [$clog2(NTMR)-1:0]       sel,
  output logic [afeed_pkg::BYTE_W-1:0]  sample,
  output logic                          req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = afeed_pkg::BYTE_W;

  logic          hit, empty;
  logic [BW-1:0] head;
  logic [CW-1:0] fill_nxt;

  assign wr_ready = 1'b1;
  assign hit      = ovf[sel];

  afeed_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .push     (wr_valid),
    .push_data(wr_data),
    .pop      (hit),
    .pop_data (head),
    .empty    (empty),
    .fill_nxt (fill_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample <= '0;
      req    <= 1'b0;
    end else if (clr) begin
      sample <= '0;
      req    <= 1'b0;
    end else begin
      req <= hit && (fill_nxt < CW'(LOW_MARK));
      if (hit) sample <= empty ? '0 : head;
    end
  end

  // R4
  req_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(hit));

  // R3
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && empty && !clr) |=> (sample == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> $stable(sample));
endmodule

// File: rtl/audio_feed.sv
`timescale 1ns/1ps
module audio_feed #(
  parameter int NCH      = 2,
  parameter int NTMR     = 4,
  parameter int NDMA     = 4,
  parameter int DMA_BASE = 1,
  parameter int DEPTH    = 32,
  parameter int LOW_MARK = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NCH-1:0]                      wr_valid,
  input  logic [NCH*afeed_pkg::WORD_W-1:0]    wr_data,
  output logic [NCH-1:0]                      wr_ready,
  input  logic [NTMR-1:0]                     tmr_ovf,
  input  logic [NCH*$clog2(NTMR)-1:0]         tmr_sel,
  input  logic [NCH-1:0]                      chan_clr,
  output logic [NCH*afeed_pkg::BYTE_W-1:0]    sample_q,
  output logic [NDMA-1:0]                     dma_req
);
  localparam int TSW = $clog2(NTMR);
  localparam int WW  = afeed_pkg::WORD_W;
  localparam int BW  = afeed_pkg::BYTE_W;

  logic [NCH-1:0] ch_req;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    afeed_chan #(.DEPTH(DEPTH), .NTMR(NTMR), .LOW_MARK(LOW_MARK)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (chan_clr[c]),
      .wr_valid(wr_valid[c]),
      .wr_data (wr_data[c*WW +: WW]),
      .wr_ready(wr_ready[c]),
      .ovf     (tmr_ovf),
      .sel     (tmr_sel[c*TSW +: TSW]),
      .sample  (sample_q[c*BW +: BW]),
      .req     (ch_req[c])
    );
  end

  always_comb begin
    dma_req = '0;
    for (int c = 0; c < NCH; c++) dma_req[c + DMA_BASE] = ch_req[c];
  end
endmodule

// File: tb/sim_audio_feed.sv
`timescale 1ns/1ps
module sim_audio_feed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wv = '0;
  logic [63:0] wd = '0;
  logic [1:0]  rdy;
  logic [3:0]  ovf = '0;
  logic [3:0]  sel = 4'b0100;
  logic [1:0]  clr = '0;
  logic [15:0] sq;
  logic [3:0]  dreq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_feed u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_data(wd), .wr_ready(rdy),
    .tmr_ovf(ovf), .tmr_sel(sel), .chan_clr(clr), .sample_q(sq), .dma_req(dreq)
  );

  typedef struct packed {
    logic [1:0]  wv;
    logic [31:0] wd;
    logic [3:0]  ovf;
    logic [7:0]  e0;
    logic [7:0]  e1;
    logic [3:0]  er;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 32'h8403_0201, 4'b0000, 8'h00, 8'h00, 4'b0000},
    '{2'b00, 32'h0,         4'b0001, 8'h01, 8'h00, 4'b0010},
    '{2'b00, 32'h0,         4'b0010, 8'h01, 8'h00, 4'b0100},
    '{2'b00, 32'h0,         4'b0100, 8'h01, 8'h00, 4'b0000},
    '{2'b10, 32'hFFEE_DD7F, 4'b0011, 8'h02, 8'h00, 4'b0110},
    '{2'b00, 32'h0,         4'b0010, 8'h02, 8'h7F, 4'b0100},
    '{2'b00, 32'h0,         4'b0001, 8'h03, 8'h7F, 4'b0010},
    '{2'b00, 32'h0,         4'b0001, 8'h84, 8'h7F, 4'b0010},
    '{2'b00, 32'h0,         4'b1000, 8'h84, 8'h7F, 4'b0000},
    '{2'b00, 32'h0,         4'b0001, 8'h00, 8'h7F, 4'b0010},
    '{2'b00, 32'h0,         4'b0010, 8'h00, 8'hDD, 4'b0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [31:0] d,
                      input logic [3:0] o, input logic [1:0] c);
    wv = v; wd = {d, d}; ovf = o; clr = c;
    @(posedge clk);
    @(negedge clk);
    wv = '0; ovf = '0; clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 latches after reset", 32'(sq), 32'h0);
    chk("R10 requests after reset", 32'(dreq), 32'h0);
    chk("R7 ready always high", 32'(rdy), 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R10 R3 empty pop after reset", 32'(sq[7:0]), 32'h0);

    // table walk: ch0 on timer 0, ch1 on timer 1
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wv, VEC[i].wd, VEC[i].ovf, 2'b00);
      chk($sformatf("R1/R2/R3/R6/R9 vec%0d ch0", i), 32'(sq[7:0]), 32'(VEC[i].e0));
      chk($sformatf("R1/R2/R3/R6/R9 vec%0d ch1", i), 32'(sq[15:8]), 32'(VEC[i].e1));
      chk($sformatf("R4/R5 vec%0d req", i), 32'(dreq), 32'(VEC[i].er));
    end

    // R1: reselect channel 1 to timer 3; timer 1 no longer acts
    sel = 4'b1100;
    step(2'b00, 32'h0, 4'b0010, 2'b00);
    chk("R1 old timer ignored latch", 32'(sq[15:8]), 32'hDD);
    chk("R1 old timer ignored req", 32'(dreq), 32'h0);
    step(2'b00, 32'h0, 4'b1000, 2'b00);
    chk("R1 new timer pops", 32'(sq[15:8]), 32'hEE);
    chk("R4 R5 ch1 request", 32'(dreq), 32'b0100);

    // R8: clear with FF still queued, then pop sees empty
    step(2'b00, 32'h0, 4'b0000, 2'b10);
    chk("R8 clear zeroes latch", 32'(sq[15:8]), 32'h0);
    step(2'b00, 32'h0, 4'b1000, 2'b00);
    chk("R8 queue empty after clear", 32'(sq[15:8]), 32'h0);
    // R8: clear overrides same-cycle write
    step(2'b10, 32'h5566_7788, 4'b0000, 2'b10);
    step(2'b00, 32'h0, 4'b1000, 2'b00);
    chk("R8 clear drops same-cycle write", 32'(sq[15:8]), 32'h0);

    // R7: fill channel 0, overfill, then partial accept
    for (int k = 0; k < 8; k++) begin
      step(2'b01, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, 4'b0000, 2'b00);
    end
    step(2'b01, 32'hA5A5_A5A5, 4'b0000, 2'b00);
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R6 first byte", 32'(sq[7:0]), 32'h00);
    chk("R4 no request at 31 bytes", 32'(dreq), 32'h0);
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R6 second byte", 32'(sq[7:0]), 32'h01);
    step(2'b01, 32'h4443_4241, 4'b0000, 2'b00);
    for (int i = 0; i < 30; i++) begin
      step(2'b00, 32'h0, 4'b0001, 2'b00);
      chk($sformatf("R7 full-drop order pop%0d", i), 32'(sq[7:0]), 32'(i + 2));
      chk($sformatf("R4 threshold pop%0d", i), 32'(dreq), (31 - i < 16) ? 32'b0010 : 32'h0);
    end
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R7 partial byte 0 kept", 32'(sq[7:0]), 32'h41);
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R7 partial byte 1 kept", 32'(sq[7:0]), 32'h42);
    step(2'b00, 32'h0, 4'b0001, 2'b00);
    chk("R7 R3 excess dropped, empty", 32'(sq[7:0]), 32'h0);
    chk("R4 R5 request on empty", 32'(dreq), 32'b0010);
    step(2'b00, 32'h0, 4'b0000, 2'b00);
    chk("R4 request is one cycle", 32'(dreq), 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule